// File: doc/BRIEF.md
# Single-Bit Branch Condition Resolver

This block decides whether a conditional branch is taken when the condition is one bit of a 32-bit register value. The bit to test is chosen in one of three ways. It can come from a constant position carried in the instruction. It can come from a run-time position read from a second register. It can also be fixed at the sign bit, which gives a cheap "is negative" test on a boolean that an earlier compare left in the top bit. A polarity bit in the instruction chooses whether the branch fires on a one or on a zero.

The decode stage presents one request per cycle with a valid strobe. One clock edge later the block returns a registered result: the taken decision, the value of the bit it examined, and a result strobe. Computing the branch target is left to other logic.

Top module: `bbt_unit`

## Requirements
- R1: While rst_n is low, and on the first edge after it is released with no request, res_valid, res_taken and res_bit are all 0.
- R2: When mode is 2'b00, the tested bit is src_val[imm_pos]. Position 0 is the least significant bit.
- R3: When mode is 2'b01, the tested bit is src_val[pos_val[4:0]]. Bits 31:5 of pos_val and all of imm_pos have no effect.
- R4: When mode is 2'b10 or 2'b11, the tested bit is src_val[31]. imm_pos and pos_val have no effect.
- R5: When polarity is 1, res_taken is 1 exactly when the tested bit is 1. When polarity is 0, res_taken is 1 exactly when the tested bit is 0.
- R6: res_bit carries the value of the bit that was tested.
- R7: A request sampled with req_valid high at a rising edge produces res_valid high, together with its result, after that same edge.
- R8: At an edge where req_valid is low, res_valid becomes 0 and res_taken and res_bit keep their previous values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A branch test request is present |
| mode | input | 2 | 00 immediate position, 01 register position, 10/11 sign bit |
| polarity | input | 1 | 1: taken on set bit, 0: taken on clear bit |
| imm_pos | input | 5 | Bit position from the instruction |
| src_val | input | 32 | Register value whose bit is tested |
| pos_val | input | 32 | Register value whose low 5 bits give the position |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_taken | output | 1 | Branch taken decision |
| res_bit | output | 1 | Value of the tested bit |

## Verification
Position selection and polarity inversion act on the same request. The bench therefore sweeps every position, under every mode, with both polarities, on walking-one, walking-zero and pseudo-random operands. In register-position mode the unused upper bits of pos_val and the immediate field carry nonzero garbage. In sign mode both position sources vary freely. Each result is compared with a bit extracted and inverted arithmetically in the bench. Idle cycles with changed inputs are placed between requests, and the held outputs are compared with the last result.

// File: rtl/bbt_pkg.sv
// Shared types for the branch bit test unit.
// Assumes: a 2-bit mode field supplied by instruction decode.
package bbt_pkg;
    typedef enum logic [1:0] {
        BBT_FIXED    = 2'b00,
        BBT_VAR      = 2'b01,
        BBT_SIGN     = 2'b10,
        BBT_SIGN_ALT = 2'b11
    } bbt_mode_e;
endpackage

// File: rtl/bbt_pos_sel.sv
// Chooses which bit position is tested, according to the mode.
// Assumes: DATA_W is a power of two, so that POS_W bits cover every position.
module bbt_pos_sel #(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  bbt_pkg::bbt_mode_e mode,
    input  logic [POS_W-1:0]   imm_pos,
    input  logic [DATA_W-1:0]  pos_val,
    output logic [POS_W-1:0]   pos
);
    localparam logic [POS_W-1:0] SIGN_POS = POS_W'(DATA_W - 1);

    // Upper bits of the position register are deliberately left unused.
    logic unused_hi;
    assign unused_hi = ^pos_val[DATA_W-1:POS_W];

    // Position multiplexer.
    always_comb begin
        case (mode)
            bbt_pkg::BBT_FIXED: pos = imm_pos;
            bbt_pkg::BBT_VAR:   pos = pos_val[POS_W-1:0];
            default:            pos = SIGN_POS;
        endcase
    end
endmodule

// File: rtl/bbt_bit_pick.sv
// Extracts one bit of the operand through a decoded AND-OR tree.
// Assumes: pos is always below DATA_W.
module bbt_bit_pick #(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [POS_W-1:0]  pos,
    output logic              bit_o
);
    logic [DATA_W-1:0] hit;

    // One decoded term per operand bit.
    for (genvar g = 0; g < DATA_W; g++) begin : g_term
        assign hit[g] = src[g] & (pos == POS_W'(g));
    end

    assign bit_o = |hit;
endmodule

// File: rtl/bbt_decide.sv
// Applies the polarity to the tested bit to form the taken decision.
// Assumes: polarity 1 means the branch fires on a set bit.
module bbt_decide (
    input  logic bit_i,
    input  logic polarity,
    output logic taken
);
    // Taken when the bit matches the requested polarity.
    always_comb taken = bit_i ^ ~polarity;
endmodule

// File: rtl/bbt_unit.sv
// Top of the branch bit test unit: combinational select and decide,
// with one output register stage and a result strobe.
// Assumes: one request per cycle; synchronous active-low reset.
module bbt_unit #(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        mode,
    input  logic              polarity,
    input  logic [POS_W-1:0]  imm_pos,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] pos_val,
    output logic              res_valid,
    output logic              res_taken,
    output logic              res_bit
);
    bbt_pkg::bbt_mode_e mode_e;
    logic [POS_W-1:0]   sel_pos;
    logic               sel_bit;
    logic               dec_taken;

    assign mode_e = bbt_pkg::bbt_mode_e'(mode);

    bbt_pos_sel #(.DATA_W(DATA_W)) u_pos (
        .mode    (mode_e),
        .imm_pos (imm_pos),
        .pos_val (pos_val),
        .pos     (sel_pos)
    );

    bbt_bit_pick #(.DATA_W(DATA_W)) u_pick (
        .src   (src_val),
        .pos   (sel_pos),
        .bit_o (sel_bit)
    );

    bbt_decide u_dec (
        .bit_i    (sel_bit),
        .polarity (polarity),
        .taken    (dec_taken)
    );

    // Result strobe follows the request by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= req_valid;
    end

    // Result data is captured on requests only and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_taken <= 1'b0;
            res_bit   <= 1'b0;
        end else if (req_valid) begin
            res_taken <= dec_taken;
            res_bit   <= sel_bit;
        end
    end
endmodule

// File: rtl/bbt_unit_chk.sv
// Protocol and function checks for bbt_unit, attached with bind.
// Assumes: the default 32-bit configuration of the position field width.
module bbt_unit_chk #(
    parameter int DATA_W = 32,
    localparam int POS_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        mode,
    input logic              polarity,
    input logic [POS_W-1:0]  imm_pos,
    input logic [DATA_W-1:0] src_val,
    input logic [DATA_W-1:0] pos_val,
    input logic              res_valid,
    input logic              res_taken,
    input logic              res_bit
);
    // R2
    fixed_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b00) |=> res_bit == $past(src_val[imm_pos]));
    // R3
    var_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'b01) |=> res_bit == $past(src_val[pos_val[POS_W-1:0]]));
    // R4
    sign_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode[1]) |=> res_bit == $past(src_val[DATA_W-1]));
    // R5
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_taken == (res_bit == $past(polarity)));
    // R7
    strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid && $stable(res_taken) && $stable(res_bit));
endmodule

bind bbt_unit bbt_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .polarity(polarity), .imm_pos(imm_pos), .src_val(src_val),
    .pos_val(pos_val), .res_valid(res_valid), .res_taken(res_taken),
    .res_bit(res_bit)
);

// File: tb/bbt_unit_tb.sv
module bbt_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        polarity = 1'b0;
    logic [4:0]  imm_pos = 5'd0;
    logic [31:0] src_val = 32'd0;
    logic [31:0] pos_val = 32'd0;
    logic        res_valid, res_taken, res_bit;
    int checks = 0;
    int errors = 0;
    logic [31:0] lfsr = 32'h1234_5678;
    logic        last_taken = 1'b0;
    logic        last_bit = 1'b0;

    always #4 clk = ~clk;

    bbt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .polarity(polarity), .imm_pos(imm_pos), .src_val(src_val),
        .pos_val(pos_val), .res_valid(res_valid), .res_taken(res_taken),
        .res_bit(res_bit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Issues one request, then samples the result after the capturing edge.
    task automatic request(input logic [1:0] m, input logic pol, input logic [4:0] ip,
                           input logic [31:0] s, input logic [31:0] p);
        int idx;
        logic b;
        logic t;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; mode = m; polarity = pol; imm_pos = ip; src_val = s; pos_val = p;
        idx = (m == 2'b00) ? int'(ip) : (m == 2'b01) ? int'(p % 32) : 31;
        b = s[idx];
        t = pol ? b : ~b;
        tag = (m == 2'b00) ? "R2" : (m == 2'b01) ? "R3" : "R4";
        @(posedge clk); #1;
        check("R7 valid", {31'd0, res_valid}, 32'd1);
        check({tag, " bit R6"}, {31'd0, res_bit}, {31'd0, b});
        check({tag, " taken R5"}, {31'd0, res_taken}, {31'd0, t});
        last_taken = t;
        last_bit = b;
    endtask

    // Holds req_valid low with scrambled inputs and checks the held outputs.
    task automatic idle();
        @(negedge clk);
        lfsr = step(lfsr);
        req_valid = 1'b0; mode = lfsr[1:0]; polarity = lfsr[2]; imm_pos = lfsr[7:3];
        src_val = ~lfsr; pos_val = lfsr;
        @(posedge clk); #1;
        check("R8 valid low", {31'd0, res_valid}, 32'd0);
        check("R8 taken hold", {31'd0, res_taken}, {31'd0, last_taken});
        check("R8 bit hold", {31'd0, res_bit}, {31'd0, last_bit});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R7 watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        src_val = 32'hFFFF_FFFF;
        polarity = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", {31'd0, res_valid}, 32'd0);
        check("R1 taken in reset", {31'd0, res_taken}, 32'd0);
        check("R1 bit in reset", {31'd0, res_bit}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 valid after release", {31'd0, res_valid}, 32'd0);
        check("R1 taken after release", {31'd0, res_taken}, 32'd0);
        check("R1 bit after release", {31'd0, res_bit}, 32'd0);

        for (int m = 0; m < 4; m++) begin
            for (int pos = 0; pos < 32; pos++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    for (int pat = 0; pat < 3; pat++) begin
                        logic [31:0] s;
                        logic [31:0] p;
                        logic [4:0]  ip;
                        lfsr = step(lfsr);
                        s = (pat == 0) ? (32'd1 << pos) : (pat == 1) ? ~(32'd1 << pos) : lfsr;
                        if (m == 0) begin
                            ip = 5'(pos); p = {lfsr[31:5], ~5'(pos)};
                        end else if (m == 1) begin
                            ip = ~5'(pos); p = {lfsr[26:0] | 27'h1, 5'(pos)};
                        end else begin
                            ip = 5'(pos); p = lfsr;
                            if (pat == 2) s[31] = pol[0] ^ pos[0];
                        end
                        request(2'(m), pol[0], ip, s, p);
                        if (pat == 2 && pos[2:0] == 3'd5) idle();
                    end
                end
            end
        end
        idle();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule